// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a directory entry from memory and, unless that entry maps a 4M region directly, reads a second-level table entry as well. It checks that the entry is present and that the request is allowed for its privilege mode and access kind. It then returns either the physical address with the merged rights and the global flag, or a fault with a small fault code. When an entry's accessed flag is clear, the walker writes that flag back. After a permitted write, it also sets the dirty flag in the final entry. Both write-backs go out before the response.

The walker serves one request at a time. A request is taken only while the block is idle. The directory base is sampled together with the request. Memory traffic uses a single-outstanding read/write port: the request is held until an acknowledge arrives, and read data is valid in the acknowledge cycle. A response is held until the consumer accepts it.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1 while rsp_valid and mem_req are 0. A request is accepted only in the idle state, and req_ready stays 0 from acceptance until the response has been consumed.
- R2: The first read goes to address {dir_base[31:12], va[31:22], 2'b00}.
- R3: When directory bit 7 is 0, the second read goes to {dir_entry[31:12], va[21:12], 2'b00}, and the physical address is {table_entry[31:12], va[11:0]}.
- R4: When directory bit 7 is 1, no second-level read is made, the physical address is {dir_entry[31:22], va[21:0]}, and rsp_large is 1.
- R5: If bit 0 (present) of the entry read at either level is 0, the walk ends with rsp_fault=1 and rsp_code bit 0 = 0.
- R6: Bit 2 of an entry grants user access and bit 1 grants writing. For a small page, each right is the AND of both levels. A user access without user rights, or a user write without write rights, faults with code bit 0 = 1.
- R7: Supervisor accesses ignore bit 1, so a supervisor write to a read-only page succeeds.
- R8: On a fault, code bit 1 equals the write flag and code bit 2 equals the user flag. Code bit 4 is 1 when a fetch carrying the no-execute flag reaches a present page; such a fault has code bit 0 = 1. Code bit 3 is always 0, and the code is 0 when there is no fault.
- R9: Each present entry read with bit 5 (accessed) clear is written back with bit 5 set, even when the access then faults. All other bits are kept, including the ignored bits 11:9. An entry whose bit 5 is already set is not rewritten unless R10 applies.
- R10: A permitted write sets bit 6 (dirty) in the final entry when it is clear, and that write completes before the response. Faulting accesses never set bit 6.
- R11: rsp_global is bit 8 of the final entry, and rsp_user and rsp_write are the effective rights. On a fault, rsp_pa, rsp_user, rsp_write, rsp_global and rsp_large are all 0.
- R12: mem_req, mem_we, mem_addr and mem_wdata are held stable until mem_ack. The response fields are held stable while rsp_valid is 1 and rsp_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_noexec | input | 1 | Execution is forbidden for this request |
| dir_base | input | 32 | Physical base of the directory, sampled with the request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_code | output | 5 | Fault code |
| rsp_pa | output | 32 | Translated physical address |
| rsp_user | output | 1 | Effective user right |
| rsp_write | output | 1 | Effective write right |
| rsp_global | output | 1 | Global flag of the final entry |
| rsp_large | output | 1 | Translation used a 4M page |

## Verification
A wrong latched entry or a wrong step choice shows up within a single walk. It appears at the memory port as an extra or missing read or write-back, or as the wrong write data. On the response side it shows as a wrong physical address, flag or fault code. So the bench counts reads and writes per walk and compares the memory image right after each response. A walker that fails to return to idle, or drops a held request, shows at once as req_ready or mem_req behaving wrongly during a stall.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // entry bit positions, decoded by the walker
   localparam int unsigned EB_PRESENT  = 0;
   localparam int unsigned EB_WRITE    = 1;
   localparam int unsigned EB_USER     = 2;
   localparam int unsigned EB_ACCESSED = 5;
   localparam int unsigned EB_DIRTY    = 6;
   localparam int unsigned EB_LARGE    = 7;
   localparam int unsigned EB_GLOBAL   = 8;

   // fault code layout
   localparam int unsigned FC_W      = 5;
   localparam int unsigned FC_PROT   = 0;
   localparam int unsigned FC_WR     = 1;
   localparam int unsigned FC_USR    = 2;
   localparam int unsigned FC_IFETCH = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_RD,
      ST_DIR_CHK,
      ST_DIR_WB,
      ST_TBL_RD,
      ST_TBL_CHK,
      ST_TBL_WB,
      ST_RESP
   } walk_state_t;

   typedef struct packed {
      logic wr;
      logic usr;
      logic fetch;
      logic noexec;
   } acc_kind_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W     = 32,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned OFF_W    = 12,
   parameter bit          LARGE_EN = 1'b1
) (
   input  logic [VA_W-1:0] va,
   input  logic [VA_W-1:0] dir_base,
   input  logic [VA_W-1:0] dir_ent,
   input  logic [VA_W-1:0] leaf_ent,
   output logic [VA_W-1:0] dir_addr,
   output logic [VA_W-1:0] tbl_addr,
   output logic [VA_W-1:0] pa_small,
   output logic [VA_W-1:0] pa_large,
   output logic            leaf_is_dir
);

   localparam int unsigned HI_LSB = VA_W - IDX_W;
   localparam int unsigned SLOT_W = OFF_W - IDX_W;

   assign dir_addr = {dir_base[VA_W-1:OFF_W], va[VA_W-1:HI_LSB], {SLOT_W{1'b0}}};
   assign tbl_addr = {dir_ent[VA_W-1:OFF_W], va[HI_LSB-1:OFF_W], {SLOT_W{1'b0}}};
   assign pa_small = {leaf_ent[VA_W-1:OFF_W], va[OFF_W-1:0]};

   generate
      if (LARGE_EN) begin : g_large
         assign pa_large    = {dir_ent[VA_W-1:HI_LSB], va[HI_LSB-1:0]};
         assign leaf_is_dir = dir_ent[EB_LARGE];
      end else begin : g_small_only
         assign pa_large    = '0;
         assign leaf_is_dir = 1'b0;
      end
   endgenerate

   logic unused_lo;
   assign unused_lo = ^{dir_base[OFF_W-1:0], dir_ent[OFF_W-1:0], leaf_ent[OFF_W-1:0]};

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
   import ptw_pkg::*;
#(
   parameter int unsigned ENT_W = 32
) (
   input  logic [ENT_W-1:0] dir_ent,
   input  logic [ENT_W-1:0] leaf_ent,
   input  logic             leaf_is_dir,
   input  logic             entry_absent,
   input  acc_kind_t        acc,
   output logic             deny,
   output logic             eff_user,
   output logic             eff_write,
   output logic             leaf_global,
   output logic [FC_W-1:0]  fcode
);

   logic rights_bad;
   logic exec_bad;

   always_comb begin
      if (leaf_is_dir) begin
         eff_user    = dir_ent[EB_USER];
         eff_write   = dir_ent[EB_WRITE];
         leaf_global = dir_ent[EB_GLOBAL];
      end else begin
         eff_user    = dir_ent[EB_USER] & leaf_ent[EB_USER];
         eff_write   = dir_ent[EB_WRITE] & leaf_ent[EB_WRITE];
         leaf_global = leaf_ent[EB_GLOBAL];
      end
   end

   // supervisor accesses skip the write-right test
   assign rights_bad = acc.usr & (~eff_user | (acc.wr & ~eff_write));
   assign exec_bad   = acc.fetch & acc.noexec;
   assign deny       = rights_bad | exec_bad;

   always_comb begin
      fcode            = '0;
      fcode[FC_PROT]   = ~entry_absent;
      fcode[FC_WR]     = acc.wr;
      fcode[FC_USR]    = acc.usr;
      fcode[FC_IFETCH] = ~entry_absent & exec_bad;
   end

   logic unused_ent;
   assign unused_ent = ^{dir_ent, leaf_ent};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W     = 32,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned OFF_W    = 12,
   parameter bit          LARGE_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_va,
   input  logic            req_write,
   input  logic            req_user,
   input  logic            req_fetch,
   input  logic            req_noexec,
   input  logic [VA_W-1:0] dir_base,
   output logic            mem_req,
   output logic            mem_we,
   output logic [VA_W-1:0] mem_addr,
   output logic [VA_W-1:0] mem_wdata,
   input  logic            mem_ack,
   input  logic [VA_W-1:0] mem_rdata,
   output logic            rsp_valid,
   input  logic            rsp_ready,
   output logic            rsp_fault,
   output logic [4:0]      rsp_code,
   output logic [VA_W-1:0] rsp_pa,
   output logic            rsp_user,
   output logic            rsp_write,
   output logic            rsp_global,
   output logic            rsp_large
);

   generate
      if (VA_W != 2 * IDX_W + OFF_W) begin : g_bad_split
         $error("ptw_walker: VA_W must equal two index fields plus the offset");
      end
      if (OFF_W != IDX_W + 2) begin : g_bad_entry
         $error("ptw_walker: a table of four-byte entries must fill one page");
      end
      if (VA_W <= EB_GLOBAL || FC_W != 5) begin : g_bad_width
         $error("ptw_walker: entry width too small for the flag layout");
      end
   endgenerate

   walk_state_t     st;
   logic [VA_W-1:0] va_q, base_q, pde_q, pte_q, wb_q;
   acc_kind_t       acc_q;

   logic [VA_W-1:0] dir_addr, tbl_addr, pa_small, pa_large;
   logic            leaf_is_dir;
   logic            entry_absent, deny, eff_user, eff_write, leaf_global;
   logic [FC_W-1:0] fcode;
   logic            fault_n;
   logic [VA_W-1:0] leaf_sel, set_mask, leaf_wb, dir_acc_wb;

   ptw_addr_gen #(
      .VA_W    (VA_W),
      .IDX_W   (IDX_W),
      .OFF_W   (OFF_W),
      .LARGE_EN(LARGE_EN)
   ) u_addr (
      .va         (va_q),
      .dir_base   (base_q),
      .dir_ent    (pde_q),
      .leaf_ent   (pte_q),
      .dir_addr   (dir_addr),
      .tbl_addr   (tbl_addr),
      .pa_small   (pa_small),
      .pa_large   (pa_large),
      .leaf_is_dir(leaf_is_dir)
   );

   assign entry_absent = (st == ST_DIR_CHK) ? ~pde_q[EB_PRESENT] : ~pte_q[EB_PRESENT];

   ptw_perm_check #(
      .ENT_W(VA_W)
   ) u_perm (
      .dir_ent     (pde_q),
      .leaf_ent    (pte_q),
      .leaf_is_dir (leaf_is_dir),
      .entry_absent(entry_absent),
      .acc         (acc_q),
      .deny        (deny),
      .eff_user    (eff_user),
      .eff_write   (eff_write),
      .leaf_global (leaf_global),
      .fcode       (fcode)
   );

   assign fault_n  = entry_absent | deny;
   assign leaf_sel = leaf_is_dir ? pde_q : pte_q;

   always_comb begin
      set_mask              = '0;
      set_mask[EB_ACCESSED] = 1'b1;
      set_mask[EB_DIRTY]    = ~fault_n & acc_q.wr;
   end

   assign leaf_wb = leaf_sel | set_mask;

   always_comb begin
      dir_acc_wb              = pde_q;
      dir_acc_wb[EB_ACCESSED] = 1'b1;
   end

   // memory port decode
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = tbl_addr;
      mem_wdata = wb_q;
      case (st)
         ST_DIR_RD: begin
            mem_req  = 1'b1;
            mem_addr = dir_addr;
         end
         ST_DIR_WB: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = dir_addr;
         end
         ST_TBL_RD: mem_req = 1'b1;
         ST_TBL_WB: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         default: ;
      endcase
   end

   assign req_ready = (st == ST_IDLE);
   assign rsp_valid = (st == ST_RESP);

   // walk sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         va_q   <= '0;
         base_q <= '0;
         pde_q  <= '0;
         pte_q  <= '0;
         wb_q   <= '0;
         acc_q  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_va;
                  base_q <= dir_base;
                  acc_q  <= '{wr: req_write, usr: req_user, fetch: req_fetch, noexec: req_noexec};
                  st     <= ST_DIR_RD;
               end
            end
            ST_DIR_RD: begin
               if (mem_ack) begin
                  pde_q <= mem_rdata;
                  st    <= ST_DIR_CHK;
               end
            end
            ST_DIR_CHK: begin
               if (entry_absent) begin
                  st <= ST_RESP;
               end else if (leaf_is_dir) begin
                  wb_q <= leaf_wb;
                  st   <= (leaf_wb != pde_q) ? ST_DIR_WB : ST_RESP;
               end else if (!pde_q[EB_ACCESSED]) begin
                  wb_q <= dir_acc_wb;
                  st   <= ST_DIR_WB;
               end else begin
                  st <= ST_TBL_RD;
               end
            end
            ST_DIR_WB: begin
               if (mem_ack) begin
                  pde_q <= wb_q;
                  st    <= leaf_is_dir ? ST_RESP : ST_TBL_RD;
               end
            end
            ST_TBL_RD: begin
               if (mem_ack) begin
                  pte_q <= mem_rdata;
                  st    <= ST_TBL_CHK;
               end
            end
            ST_TBL_CHK: begin
               if (entry_absent) begin
                  st <= ST_RESP;
               end else begin
                  wb_q <= leaf_wb;
                  st   <= (leaf_wb != pte_q) ? ST_TBL_WB : ST_RESP;
               end
            end
            ST_TBL_WB: begin
               if (mem_ack) st <= ST_RESP;
            end
            ST_RESP: begin
               if (rsp_ready) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // response registers, loaded when a level is judged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_fault  <= 1'b0;
         rsp_code   <= '0;
         rsp_pa     <= '0;
         rsp_user   <= 1'b0;
         rsp_write  <= 1'b0;
         rsp_global <= 1'b0;
         rsp_large  <= 1'b0;
      end else if (st == ST_DIR_CHK || st == ST_TBL_CHK) begin
         rsp_fault  <= fault_n;
         rsp_code   <= fault_n ? fcode : '0;
         rsp_pa     <= fault_n ? '0 : (leaf_is_dir ? pa_large : pa_small);
         rsp_user   <= ~fault_n & eff_user;
         rsp_write  <= ~fault_n & eff_write;
         rsp_global <= ~fault_n & leaf_global;
         rsp_large  <= ~fault_n & leaf_is_dir;
      end
   end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            mem_req,
   input logic            mem_we,
   input logic [VA_W-1:0] mem_addr,
   input logic [VA_W-1:0] mem_wdata,
   input logic            mem_ack,
   input logic            rsp_valid,
   input logic            rsp_ready,
   input logic            rsp_fault,
   input logic [4:0]      rsp_code,
   input logic [VA_W-1:0] rsp_pa,
   input logic            rsp_user,
   input logic            rsp_write,
   input logic            rsp_global,
   input logic            rsp_large
);

   // R1
   idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req && !rsp_valid));

   // R1
   single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R12
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

   // R12
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_code) && $stable(rsp_pa)));

   // R8
   code_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!rsp_code[3] && (rsp_fault || rsp_code == 5'd0)));

   // R5
   absent_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault && !rsp_code[FC_PROT]) |-> !rsp_code[FC_IFETCH]);

   // R11
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && !rsp_user && !rsp_write && !rsp_global && !rsp_large));

   // R9
   wb_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[EB_ACCESSED] && mem_wdata[EB_PRESENT]));

endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W)) u_chk (.*);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

   localparam logic [31:0] BASE = 32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ready;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0, req_noexec = 1'b0;
   logic [31:0] dir_base = BASE;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        rsp_valid, rsp_ready = 1'b1, rsp_fault;
   logic [4:0]  rsp_code;
   logic [31:0] rsp_pa;
   logic        rsp_user, rsp_write, rsp_global, rsp_large;

   always #4 clk = ~clk;

   ptw_walker u_ptw_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
      .req_noexec(req_noexec), .dir_base(dir_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
      .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_user(rsp_user),
      .rsp_write(rsp_write), .rsp_global(rsp_global), .rsp_large(rsp_large)
   );

   // backing memory, one access per acknowledge
   logic [31:0] mem [logic [31:0]];
   int rd_cnt = 0, wr_cnt = 0, rd_base = 0, wr_base = 0;

   function automatic logic [31:0] mrd(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt = wr_cnt + 1;
         end else begin
            mem_rdata <= mrd(mem_addr);
            rd_cnt = rd_cnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   typedef struct {
      logic        fault;
      logic [4:0]  code;
      logic [31:0] pa;
      logic [3:0]  flags;
      int          nrd, nwr;
      logic [31:0] a1, v1, a2, v2;
      bit          has2;
      string       tag, ctag;
   } exp_t;

   exp_t q[$];
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // reference walk computed from the requirements
   function automatic exp_t model(logic [31:0] va, logic wr, logic usr, logic fe, logic nx, string tag);
      exp_t e;
      logic [31:0] pde, pte, leaf, nleaf;
      logic eu, ew, lg, bad, xb;
      e.tag = tag; e.fault = 0; e.code = 0; e.pa = 0; e.flags = 0;
      e.nrd = 1; e.nwr = 0; e.has2 = 0; e.a2 = 0; e.v2 = 0;
      e.a1 = {BASE[31:12], va[31:22], 2'b00};
      pde = mrd(e.a1);
      e.v1 = pde;
      e.ctag = "R5";
      if (!pde[0]) begin
         e.fault = 1; e.code = {2'b00, usr, wr, 1'b0};
         return e;
      end
      if (pde[7]) begin
         leaf = pde; eu = pde[2]; ew = pde[1]; lg = 1; e.ctag = "R4";
      end else begin
         lg = 0;
         if (!pde[5]) e.nwr++;
         e.v1 = pde | 32'h20;
         e.a2 = {pde[31:12], va[21:12], 2'b00};
         pte = mrd(e.a2);
         e.v2 = pte; e.has2 = 1; e.nrd = 2;
         if (!pte[0]) begin
            e.fault = 1; e.code = {2'b00, usr, wr, 1'b0};
            return e;
         end
         e.ctag = "R3";
         leaf = pte; eu = pde[2] & pte[2]; ew = pde[1] & pte[1];
      end
      xb  = fe & nx;
      bad = (usr & (!eu | (wr & !ew))) | xb;
      nleaf = leaf | 32'h20 | ((!bad && wr) ? 32'h40 : 32'h0);
      if (nleaf != leaf) e.nwr++;
      if (lg) e.v1 = nleaf; else e.v2 = nleaf;
      if (bad) begin
         e.fault = 1; e.code = {xb, 1'b0, usr, wr, 1'b1};
      end else begin
         e.pa = lg ? {pde[31:22], va[21:0]} : {pte[31:12], va[11:0]};
         e.flags = {eu, ew, leaf[8], lg};
      end
      return e;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid && rsp_ready) begin
         if (q.size() == 0) begin
            chk(0, "R1", "unexpected response", 32'h1, 32'h0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(rsp_fault == e.fault, e.tag, "fault", {31'b0, rsp_fault}, {31'b0, e.fault});
            chk(rsp_code == e.code, "R8", "code", {27'b0, rsp_code}, {27'b0, e.code});
            chk(rsp_pa == e.pa, e.tag, "paddr", rsp_pa, e.pa);
            chk({rsp_user, rsp_write, rsp_global, rsp_large} == e.flags, "R11", "flags",
                {28'b0, rsp_user, rsp_write, rsp_global, rsp_large}, {28'b0, e.flags});
            chk(rd_cnt - rd_base == e.nrd, e.ctag, "read count", rd_cnt - rd_base, e.nrd);
            chk(wr_cnt - wr_base == e.nwr, "R9/R10", "write count", wr_cnt - wr_base, e.nwr);
            chk(mrd(e.a1) == e.v1, "R9/R10", "dir entry after walk", mrd(e.a1), e.v1);
            if (e.has2)
               chk(mrd(e.a2) == e.v2, "R9/R10", "table entry after walk", mrd(e.a2), e.v2);
            rd_base = rd_cnt;
            wr_base = wr_cnt;
         end
      end
   end

   task automatic walk(logic [31:0] va, logic wr, logic usr, logic fe, logic nx, string tag, int stall);
      exp_t e;
      bit acc;
      @(posedge clk); #2;
      e = model(va, wr, usr, fe, nx, tag);
      q.push_back(e);
      if (stall > 0) rsp_ready = 1'b0;
      req_va = va; req_write = wr; req_user = usr; req_fetch = fe; req_noexec = nx;
      req_valid = 1'b1;
      do begin
         @(negedge clk);
         acc = req_ready;
         @(posedge clk); #2;
      end while (!acc);
      req_valid = 1'b0;
      if (stall > 0) begin
         while (!rsp_valid) @(negedge clk);
         repeat (stall) @(negedge clk);
         chk(rsp_valid == 1'b1, "R12", "valid held under stall", {31'b0, rsp_valid}, 32'h1);
         chk(req_ready == 1'b0, "R1", "busy while response pending", {31'b0, req_ready}, 32'h0);
         chk(rsp_pa == e.pa, "R12", "paddr held under stall", rsp_pa, e.pa);
         @(posedge clk); #2;
         rsp_ready = 1'b1;
      end
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      finish_up();
   end

   initial begin
      // directory
      mem[BASE + 32'h4]  = 32'h0002_0007;   // idx1: table at 0x20000, user rw
      mem[BASE + 32'h8]  = 32'h0000_0000;   // idx2: absent
      mem[BASE + 32'hC]  = 32'h0C00_0083;   // idx3: large, supervisor, rw
      mem[BASE + 32'h10] = 32'h0003_0005;   // idx4: table at 0x30000, user read-only
      mem[BASE + 32'h14] = 32'h0004_0027;   // idx5: table at 0x40000, accessed
      // tables
      mem[32'h0002_000C] = 32'h0ABC_D107;   // global, user rw
      mem[32'h0002_0018] = 32'h0123_4E07;   // ignored bits set
      mem[32'h0003_0000] = 32'h0055_5007;
      mem[32'h0004_0008] = 32'h0077_7063;   // supervisor, accessed, dirty

      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "req_ready after reset", {31'b0, req_ready}, 32'h1);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
      chk(mem_req == 1'b0, "R1", "mem_req after reset", {31'b0, mem_req}, 32'h0);

      walk(32'h0040_3123, 0, 1, 0, 0, "R2", 0);   // small page, accessed on both levels
      walk(32'h0040_3124, 1, 1, 0, 0, "R10", 0);  // dirty set
      walk(32'h0040_3125, 1, 1, 0, 0, "R10", 0);  // nothing left to write
      walk(32'h0080_0000, 0, 1, 0, 0, "R5", 0);   // absent directory entry
      walk(32'h0040_5000, 1, 1, 0, 0, "R5", 0);   // absent table entry
      walk(32'h00C1_2345, 0, 0, 0, 0, "R4", 0);   // large page
      walk(32'h00C1_2345, 0, 1, 0, 0, "R6", 0);   // user on supervisor large page
      walk(32'h00C0_0010, 1, 0, 0, 0, "R7", 0);   // supervisor write, dirty on directory
      walk(32'h0100_0ABC, 1, 1, 0, 0, "R6", 0);   // user write, read-only directory
      walk(32'h0100_0ABC, 1, 0, 0, 0, "R7", 0);   // supervisor write to read-only
      walk(32'h0100_0ABC, 0, 1, 0, 0, "R6", 0);   // user read allowed
      walk(32'h0040_3FF0, 0, 1, 1, 1, "R8", 0);   // blocked user fetch
      walk(32'h0040_3FF0, 0, 0, 1, 1, "R8", 0);   // blocked supervisor fetch
      walk(32'h0040_3FF0, 0, 1, 1, 0, "R8", 0);   // allowed fetch
      walk(32'h0040_6004, 0, 0, 0, 0, "R9", 0);   // ignored bits kept
      walk(32'h0140_2800, 0, 0, 0, 0, "R11", 0);  // no write-back, non-global
      walk(32'h0140_2800, 0, 1, 0, 0, "R6", 0);   // supervisor-only table entry
      walk(32'h0040_3008, 0, 0, 0, 0, "R12", 6);  // response stalled
      walk(32'h00C3_FFFF, 0, 0, 0, 0, "R4", 0);

      repeat (4) @(posedge clk);
      finish_up();
   end

endmodule